// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Switcher

This block maps an 8 KB cartridge ROM window onto a much larger linear flash or ROM image. The host picks a bank by writing to any location inside the window. The value written does not select the bank. The block takes the bank number from the address lines of that write. The window can therefore never hold written data: every write into it is a bank change.

On reads, the block places the stored bank number above the 13-bit offset inside the window and drives the result as a wide memory address, together with a read enable. The number of address lines used as bank bits is a parameter, from one to twelve. A build option also takes the two lowest data bits of the same write as two extra high bank bits. A mask parameter trims the stored bank so that smaller images wrap.

Address lines use big-endian numbering: line 0 is the most significant and line 15 the least. Lines 0 to 2 do not reach the cartridge port.

Top module: `cartbank_top`

## Requirements
- R1: A synchronous active-high reset sets the stored bank to 0, the read enable to 0 and the memory address to 0.
- R2: When `win_sel` and `wr_strobe` are both high on a clock edge, a bank change is armed. The change takes effect at the first following edge where `wr_strobe` is low. Bank bit i is taken from address line 14-i, for i from 0 to BANK_BITS-1.
- R3: Address line 15 and address lines 0 to 2 never affect the stored bank.
- R4: Only BANK_BITS address lines are used. With BANK_BITS=8, lines 3 to 6 have no effect on the bank.
- R5: With DATA_EXT=1, data bits 0 and 1 of the write become bank bits BANK_BITS and BANK_BITS+1. With DATA_EXT=0, the data bus has no effect.
- R6: The stored bank is the captured value ANDed with BANK_MASK, so bank numbers beyond the mask wrap.
- R7: One clock after an edge, `mem_addr` equals {stored bank, address lines 3..15}, with line 15 in bit 0.
- R8: One clock after an edge, `mem_rd_en` is high exactly when `win_sel` was high and `wr_strobe` was low at that edge.
- R9: A write strobe while `win_sel` is low leaves the stored bank unchanged.
- R10: Reads leave the stored bank unchanged; it holds until the next armed write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_sel | input | 1 | Cartridge ROM window select, active high |
| wr_strobe | input | 1 | Host write strobe, active high |
| host_addr | input | 16 | Host address lines, indexed [0:15], line 0 most significant |
| host_data | input | 8 | Host data bus; bits 1:0 are the optional extra bank bits |
| mem_addr | output | 13+BANK_BITS+2*DATA_EXT | Linear memory address, registered |
| mem_rd_en | output | 1 | Memory read enable, registered |

## Verification
The bench builds two copies of the block that share the same stimulus:
- **Full build:** the defaults, with twelve address bank bits, the data extension on and a full mask. This exercises every address line from 3 to 14 and the two data-driven bank bits, giving a 27-bit address.
- **Narrow build:** eight bank bits, no data extension and a mask of 0x3F. This makes it possible to watch unused lines 3 to 6 and the data bus being ignored, and bank numbers wrapping under the mask.

// File: rtl/cartbank_pkg.sv
package cartbank_pkg;
  localparam int OFFSET_BITS   = 13;
  localparam int ADDR_LINES    = 16;
  localparam int MAX_ADDR_BANK = 12;
  localparam int EXT_BITS      = 2;
  localparam int LOW_BANK_LINE = 14;
  localparam int FIRST_LINE    = 3;

  function automatic int total_bank_bits(input int addr_bits, input int ext);
    return addr_bits + (ext != 0 ? EXT_BITS : 0);
  endfunction
endpackage

// File: rtl/cartbank_strobe_trk.sv
module cartbank_strobe_trk
  import cartbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 win_sel,
  input  logic                 wr_strobe,
  input  logic [0:ADDR_LINES-1] host_addr,
  input  logic [EXT_BITS-1:0]  host_data_lo,
  output logic                 commit,
  output logic [FIRST_LINE:LOW_BANK_LINE] cap_lines,
  output logic [EXT_BITS-1:0]  cap_data
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      cap_lines <= '0;
      cap_data  <= '0;
    end else if (win_sel && wr_strobe) begin
      armed_q   <= 1'b1;
      cap_lines <= host_addr[FIRST_LINE:LOW_BANK_LINE];
      cap_data  <= host_data_lo;
    end else if (!wr_strobe) begin
      armed_q   <= 1'b0;
    end
  end

  // trailing edge of an armed strobe
  assign commit = armed_q && !wr_strobe;
endmodule

// File: rtl/cartbank_bank_reg.sv
module cartbank_bank_reg
  import cartbank_pkg::*;
#(
  parameter int BANK_BITS = 12,
  parameter int DATA_EXT  = 1,
  parameter int TOTAL     = total_bank_bits(BANK_BITS, DATA_EXT),
  parameter logic [TOTAL-1:0] MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit,
  input  logic [FIRST_LINE:LOW_BANK_LINE] cap_lines,
  input  logic [EXT_BITS-1:0]  cap_data,
  output logic [TOTAL-1:0]     bank_q
);
  logic [TOTAL-1:0] raw_bank;

  genvar g;
  generate
    for (g = 0; g < BANK_BITS; g++) begin : g_line
      assign raw_bank[g] = cap_lines[LOW_BANK_LINE - g];
    end
    if (DATA_EXT != 0) begin : g_ext
      assign raw_bank[BANK_BITS +: EXT_BITS] = cap_data;
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = ^cap_data;
    end
    if (BANK_BITS < MAX_ADDR_BANK) begin : g_spare
      logic unused_lines;
      assign unused_lines = ^cap_lines[FIRST_LINE:LOW_BANK_LINE-BANK_BITS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bank_q <= '0;
    else if (commit) bank_q <= raw_bank & MASK;
  end
endmodule

// File: rtl/cartbank_addr_out.sv
module cartbank_addr_out
  import cartbank_pkg::*;
#(
  parameter int TOTAL = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        win_sel,
  input  logic                        wr_strobe,
  input  logic [TOTAL-1:0]            bank_q,
  input  logic [OFFSET_BITS-1:0]      offset,
  output logic [TOTAL+OFFSET_BITS-1:0] mem_addr,
  output logic                        mem_rd_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_rd_en <= 1'b0;
    end else begin
      mem_addr  <= {bank_q, offset};
      mem_rd_en <= win_sel && !wr_strobe;
    end
  end
endmodule

// File: rtl/cartbank_top.sv
module cartbank_top
  import cartbank_pkg::*;
#(
  parameter int BANK_BITS = 12,
  parameter int DATA_EXT  = 1,
  parameter logic [MAX_ADDR_BANK+EXT_BITS-1:0] BANK_MASK = '1,
  localparam int TOTAL_BITS = total_bank_bits(BANK_BITS, DATA_EXT),
  localparam int MEM_AW     = OFFSET_BITS + TOTAL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_sel,
  input  logic              wr_strobe,
  input  logic [0:15]       host_addr,
  input  logic [7:0]        host_data,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd_en
);
  logic                           commit;
  logic [FIRST_LINE:LOW_BANK_LINE] cap_lines;
  logic [EXT_BITS-1:0]            cap_data;
  logic [TOTAL_BITS-1:0]          bank_q;
  logic                           unused_pins;

  // lines 0..2 are absent at the port; high data bits never bank
  assign unused_pins = ^{host_addr[0:FIRST_LINE-1], host_data[7:EXT_BITS]};

  cartbank_strobe_trk u_trk (
    .clk          (clk),
    .rst          (rst),
    .win_sel      (win_sel),
    .wr_strobe    (wr_strobe),
    .host_addr    (host_addr),
    .host_data_lo (host_data[EXT_BITS-1:0]),
    .commit       (commit),
    .cap_lines    (cap_lines),
    .cap_data     (cap_data)
  );

  cartbank_bank_reg #(
    .BANK_BITS (BANK_BITS),
    .DATA_EXT  (DATA_EXT),
    .TOTAL     (TOTAL_BITS),
    .MASK      (BANK_MASK[TOTAL_BITS-1:0])
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .cap_lines (cap_lines),
    .cap_data  (cap_data),
    .bank_q    (bank_q)
  );

  cartbank_addr_out #(
    .TOTAL (TOTAL_BITS)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .win_sel   (win_sel),
    .wr_strobe (wr_strobe),
    .bank_q    (bank_q),
    .offset    (host_addr[FIRST_LINE:ADDR_LINES-1]),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en)
  );
endmodule

// File: rtl/cartbank_chk.sv
module cartbank_chk
  import cartbank_pkg::*;
#(
  parameter int TOTAL  = 14,
  parameter int MEM_AW = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              win_sel,
  input logic              wr_strobe,
  input logic [0:15]       host_addr,
  input logic [TOTAL-1:0]  bank_q,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rd_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (bank_q == '0 && !mem_rd_en && mem_addr == '0));

  // R8
  rd_enable_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> $past(win_sel && !wr_strobe));

  // R7
  addr_form_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_addr == {$past(bank_q), $past(host_addr[FIRST_LINE:ADDR_LINES-1])}));

  // R9
  bank_change_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_q != $past(bank_q)) |-> ($past(!wr_strobe) && $past(wr_strobe, 2) && $past(win_sel, 2)));

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_strobe) && $past(!wr_strobe, 2)) |-> $stable(bank_q));
endmodule

bind cartbank_top cartbank_chk #(
  .TOTAL  (TOTAL_BITS),
  .MEM_AW (MEM_AW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .win_sel   (win_sel),
  .wr_strobe (wr_strobe),
  .host_addr (host_addr),
  .bank_q    (bank_q),
  .mem_addr  (mem_addr),
  .mem_rd_en (mem_rd_en)
);

// File: tb/cartbank_top_tb_top.sv
module cartbank_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        win_sel = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [0:15] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic [26:0] big_addr;
  logic        big_rd;
  logic [20:0] sm_addr;
  logic        sm_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cartbank_top dut_i (
    .clk(clk), .rst(rst), .win_sel(win_sel), .wr_strobe(wr_strobe),
    .host_addr(host_addr), .host_data(host_data),
    .mem_addr(big_addr), .mem_rd_en(big_rd));

  cartbank_top #(.BANK_BITS(8), .DATA_EXT(0), .BANK_MASK(14'h003F)) dut_small_i (
    .clk(clk), .rst(rst), .win_sel(win_sel), .wr_strobe(wr_strobe),
    .host_addr(host_addr), .host_data(host_data),
    .mem_addr(sm_addr), .mem_rd_en(sm_rd));

  // bank bit i on line 14-i; offset on lines 3..15
  function automatic logic [0:15] mk_addr(input logic [11:0] bank, input logic [2:0] top3,
                                          input logic l15);
    logic [0:15] a;
    a = '0;
    a[0:2] = top3;
    for (int i = 0; i < 12; i++) a[14 - i] = bank[i];
    a[15] = l15;
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [0:15] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    win_sel = sel; wr_strobe = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    chk("R8 rd low during write", {31'b0, big_rd}, 32'd0);
    wr_strobe = 1'b0;
    @(negedge clk);
    win_sel = 1'b0; host_addr = '0; host_data = '0;
  endtask

  task automatic do_read(input logic [12:0] off, input logic [13:0] exp_big,
                         input logic [7:0] exp_sm, input string req);
    @(negedge clk);
    win_sel = 1'b1; wr_strobe = 1'b0; host_addr = '0; host_addr[3:15] = off;
    @(negedge clk);
    chk(req, {5'b0, big_addr}, {5'b0, exp_big, off});
    chk(req, {11'b0, sm_addr}, {11'b0, exp_sm, off});
    chk("R8 rd high on read", {30'b0, big_rd, sm_rd}, 32'd3);
    win_sel = 1'b0;
    @(negedge clk);
    chk("R8 rd low when unselected", {30'b0, big_rd, sm_rd}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset addr", {5'b0, big_addr}, 32'd0);
    chk("R1 reset small addr", {11'b0, sm_addr}, 32'd0);
    chk("R1 reset rd", {30'b0, big_rd, sm_rd}, 32'd0);
    do_read(13'h0ABC, 14'h0, 8'h0, "R1 bank zero after reset");
  endtask

  task automatic t_basic();
    do_write(mk_addr(12'hA5C, 3'b000, 1'b0), 8'h00, 1'b1);
    do_read(13'h1234, 14'h0A5C, 8'h5C & 8'h3F, "R2 R7 address lines to bank");
    do_write(mk_addr(12'h001, 3'b000, 1'b0), 8'h00, 1'b1);
    do_read(13'h1FFF, 14'h0001, 8'h01, "R2 single low bank bit");
    do_write(mk_addr(12'h800, 3'b000, 1'b0), 8'h00, 1'b1);
    do_read(13'h0000, 14'h0800, 8'h00, "R2 R4 line 3 top bank bit");
  endtask

  task automatic t_ignored_lines();
    do_write(mk_addr(12'h123, 3'b111, 1'b1), 8'h00, 1'b1);
    do_read(13'h0F0F, 14'h0123, 8'h23, "R3 lines 0-2 and 15 ignored");
  endtask

  task automatic t_narrow();
    do_write(mk_addr(12'hF00, 3'b000, 1'b0), 8'h00, 1'b1);
    do_read(13'h0555, 14'h0F00, 8'h00, "R4 lines 3..6 unused in narrow build");
    do_write(mk_addr(12'h0FF, 3'b000, 1'b0), 8'h00, 1'b1);
    do_read(13'h0001, 14'h00FF, 8'h3F, "R6 mask wraps narrow bank");
  endtask

  task automatic t_data_ext();
    do_write(mk_addr(12'h3FF, 3'b000, 1'b0), 8'hFE, 1'b1);
    do_read(13'h0100, 14'h23FF, 8'h3F, "R5 data bits extend bank");
    do_write(mk_addr(12'h3FF, 3'b000, 1'b0), 8'h03, 1'b1);
    do_read(13'h0100, 14'h33FF, 8'h3F, "R5 both data bits");
  endtask

  task automatic t_unselected_write();
    do_write(mk_addr(12'h777, 3'b000, 1'b0), 8'h01, 1'b0);
    do_read(13'h0002, 14'h33FF, 8'h3F, "R9 write without select ignored");
  endtask

  task automatic t_hold();
    do_read(13'h1000, 14'h33FF, 8'h3F, "R10 bank held over reads");
    do_read(13'h0FFF, 14'h33FF, 8'h3F, "R10 bank held again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_ignored_lines();
    t_narrow();
    t_data_ext();
    t_unselected_write();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule